// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Stage

This block is one pass of a pipelined 256-point complex FFT in decimation-in-frequency form. The previous stage, or the front end for the first stage, fills the block's local dual-port RAM through a write port. The first stage is fed with 12-bit pixel samples, sign-extended to 16 bits. A one-cycle `start` pulse then launches a pass of 128 butterflies. A pass reads each pair of points, forms their halved sum and their halved twiddled difference, and writes both results out through a write port that feeds the next stage's RAM.

A single signed 18x18 multiplier forms the complex twiddle product over four cycles. A new butterfly therefore starts every fourth cycle, and a result word leaves on every second cycle. Each result is halved, so a chain of eight stages scales the transform by 1/256 and the values stay inside 16-bit words. When the last result has been written, the block raises `done` for one cycle, and that pulse starts the next stage. The stage index is a parameter. It sets the distance between paired points and the step through the twiddle table. After the last stage the spectrum comes out in bit-reversed order.

Top module: `fft_bfly_stage`

## Requirements
- R1: Butterfly b (0..N/2-1) pairs the lower address a and the upper address c = a + H, with H = 2^(log2N-1-STAGE). a is b with a 0 bit inserted at bit position log2(H). Each pass writes each of the N addresses exactly once, in butterfly order, and writes a before c.
- R2: The word written to a is ((x[a] + x[c]) >>> 1), computed exactly for both the real and the imaginary part.
- R3: With d = x[a] - x[c] held as a 17-bit value and W = C - jS, the word written to c has real part (dr·C + di·S) >>> 16 and imaginary part (di·C - dr·S) >>> 16. The shift is a floor shift: 15 bits for the Q1.15 twiddle plus 1 bit for the halving.
- R4: A result of R3 that falls outside the signed 16-bit range is clipped to 32767 or -32768.
- R5: C and S are round-half-away-from-zero of 32768·cos(2πk/N) and 32768·sin(2πk/N), with any value above 32767 clipped to 32767. The index is k = (b mod H)·2^STAGE.
- R6: Counting from the clock edge that accepts `start` as cycle 0, write number i (0..N-1) falls in cycle 4 + 2i. At most one write happens per cycle, and no write happens outside a pass.
- R7: `done` is high for exactly one cycle. It rises 4·(N/2) + 3 cycles after the accepting edge, in the cycle right after the last write.
- R8: A `start` that arrives while a pass is running is ignored and does not move any write or the `done` pulse.
- R9: A load-port write that arrives while a pass is running does not alter the local RAM. A pass never alters the local RAM either, so a second `start` with no reload gives identical results.
- R10: While reset is low and after it is released, `out_we` and `done` stay low until a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a pass while idle |
| in_we | input | 1 | Load-port write strobe into the local RAM (idle only) |
| in_addr | input | N_LOG2 | Load-port address |
| in_re | input | DATA_W | Real part to load |
| in_im | input | DATA_W | Imaginary part to load |
| out_we | output | 1 | Result write strobe toward the next stage |
| out_addr | output | N_LOG2 | Result address |
| out_re | output | DATA_W | Result real part |
| out_im | output | DATA_W | Result imaginary part |
| done | output | 1 | One-cycle pulse after the last result of a pass |

## Verification
Two collisions are provoked on purpose: a load-port write landing in a cycle where the sequencer reads the RAM, and a second `start` arriving while a butterfly is in flight. One pass of random full-range data injects a burst of load writes and a stray `start` in the middle of the pass. That pass is judged by comparing every result word, its address and its cycle against the arithmetic model computed from the data loaded before the pass. A following pass with no reload must reproduce the same results. A saturating pattern drives the difference path to its clip limits at the 45-degree twiddle.

// File: rtl/fft_stage_pkg.sv
// Shared types and elaboration-time math for the FFT butterfly stage.
// Assumes twiddle angles lie in [0, pi), where a 16-term series is exact
// well beyond Q1.15 resolution.
package fft_stage_pkg;

    // Multiplier phase, taken from the two low bits of the pass counter.
    typedef enum logic [1:0] {
        PH_IM_LOAD = 2'd0,
        PH_IM_SUB  = 2'd1,
        PH_RE_LOAD = 2'd2,
        PH_RE_ADD  = 2'd3
    } mul_phase_e;

    localparam real PI_C = 3.14159265358979323846;

    // Cosine by power series
    function automatic real ser_cos(input real x);
        real t;
        real s;
        t = 1.0;
        s = 1.0;
        for (int i = 1; i <= 16; i++) begin
            t = -t * x * x / real'((2 * i - 1) * (2 * i));
            s = s + t;
        end
        return s;
    endfunction

    // Sine by power series
    function automatic real ser_sin(input real x);
        real t;
        real s;
        t = x;
        s = x;
        for (int i = 1; i <= 16; i++) begin
            t = -t * x * x / real'((2 * i) * (2 * i + 1));
            s = s + t;
        end
        return s;
    endfunction

    // Round half away from zero to a fixed-point integer with frac bits, clipped
    function automatic int q_round(input real v, input int frac);
        real r;
        int  q;
        r = v * (2.0 ** frac);
        q = (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
        if (q > (1 << frac) - 1) q = (1 << frac) - 1;
        if (q < -(1 << frac))    q = -(1 << frac);
        return q;
    endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
// Cosine/sine table for the first half circle, one registered read per cycle.
// Entry k holds {C, S} in Q1.15 for angle 2*pi*k/NPTS. Contents are computed
// at start-up; the array maps to a ROM.
module fft_twiddle_rom
    import fft_stage_pkg::*;
#(
    parameter int N_LOG2 = 8,
    parameter int TW_W   = 16
) (
    input  logic                     clk,
    input  logic [N_LOG2-2:0]        addr,
    output logic signed [TW_W-1:0]   cos_q,
    output logic signed [TW_W-1:0]   sin_q
);
    localparam int NPTS  = 1 << N_LOG2;
    localparam int DEPTH = NPTS / 2;

    logic [2*TW_W-1:0] rom [DEPTH];

    // Fill the table from the series functions
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            real ang;
            ang = 2.0 * PI_C * real'(k) / real'(NPTS);
            rom[k] = {TW_W'(q_round(ser_cos(ang), TW_W - 1)),
                      TW_W'(q_round(ser_sin(ang), TW_W - 1))};
        end
    end

    // Registered read, same latency as the data RAM
    always_ff @(posedge clk) begin
        {cos_q, sin_q} <= rom[addr];
    end
endmodule

// File: rtl/fft_stage_ram.sv
// Local stage memory: port A writes or reads, port B only reads.
// Both reads are registered (one-cycle latency).
module fft_stage_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] mem [1 << AW];

    // Port A write and both registered reads
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/fft_bfly_datapath.sv
// Butterfly arithmetic with one shared multiplier.
// Captures the operand pair and twiddle when cap is high, then over the four
// phases forms re = dr*C + di*S and im = di*C - dr*S. Outputs: halved sum
// (exact) and difference product shifted by TW_W bits and clipped to DATA_W.
// Assumes DATA_W+1 <= MUL_W and TW_W < MUL_W.
module fft_bfly_datapath
    import fft_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TW_W   = 16,
    parameter int MUL_W  = 18
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     cap,
    input  mul_phase_e               ph,
    input  logic signed [DATA_W-1:0] xa_re,
    input  logic signed [DATA_W-1:0] xa_im,
    input  logic signed [DATA_W-1:0] xc_re,
    input  logic signed [DATA_W-1:0] xc_im,
    input  logic signed [TW_W-1:0]   w_cos,
    input  logic signed [TW_W-1:0]   w_sin,
    output logic signed [DATA_W-1:0] top_re,
    output logic signed [DATA_W-1:0] top_im,
    output logic signed [DATA_W-1:0] bot_re,
    output logic signed [DATA_W-1:0] bot_im
);
    localparam int SW    = DATA_W + 1;
    localparam int PW    = 2 * MUL_W;
    localparam int ACC_W = PW + 1;
    localparam int SHIFT = TW_W;

    logic signed [SW-1:0]     sum_re, sum_im, dif_re, dif_im;
    logic signed [DATA_W-1:0] hs_re, hs_im;
    logic signed [SW-1:0]     d_re, d_im;
    logic signed [TW_W-1:0]   wc, ws;
    logic signed [SW-1:0]     sel_d;
    logic signed [TW_W-1:0]   sel_w;
    logic signed [MUL_W-1:0]  op_d, op_w;
    logic signed [PW-1:0]     prod;
    logic signed [ACC_W-1:0]  prod_x, acc_re, acc_im;

    // Shift right by SHIFT and clip to the DATA_W range
    function automatic logic signed [DATA_W-1:0] scale_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] sh;
        sh = v >>> SHIFT;
        if ((&sh[ACC_W-1:DATA_W-1]) || !(|sh[ACC_W-1:DATA_W-1]))
            return sh[DATA_W-1:0];
        else if (sh[ACC_W-1])
            return {1'b1, {(DATA_W-1){1'b0}}};
        else
            return {1'b0, {(DATA_W-1){1'b1}}};
    endfunction

    // Sum and difference with MSB-replicated sign extension
    always_comb begin
        sum_re = $signed({xa_re[DATA_W-1], xa_re}) + $signed({xc_re[DATA_W-1], xc_re});
        sum_im = $signed({xa_im[DATA_W-1], xa_im}) + $signed({xc_im[DATA_W-1], xc_im});
        dif_re = $signed({xa_re[DATA_W-1], xa_re}) - $signed({xc_re[DATA_W-1], xc_re});
        dif_im = $signed({xa_im[DATA_W-1], xa_im}) - $signed({xc_im[DATA_W-1], xc_im});
    end

    // Capture one butterfly's operands for the four multiply phases
    always_ff @(posedge clk) begin
        if (cap) begin
            hs_re <= sum_re[SW-1:1];
            hs_im <= sum_im[SW-1:1];
            d_re  <= dif_re;
            d_im  <= dif_im;
            wc    <= w_cos;
            ws    <= w_sin;
        end
    end

    // Operand selection for the shared multiplier
    always_comb begin
        case (ph)
            PH_RE_LOAD: begin sel_d = d_re; sel_w = wc; end
            PH_RE_ADD:  begin sel_d = d_im; sel_w = ws; end
            PH_IM_LOAD: begin sel_d = d_im; sel_w = wc; end
            default:    begin sel_d = d_re; sel_w = ws; end
        endcase
        op_d   = $signed({{(MUL_W-SW){sel_d[SW-1]}}, sel_d});
        op_w   = $signed({{(MUL_W-TW_W){sel_w[TW_W-1]}}, sel_w});
        prod   = op_d * op_w;
        prod_x = $signed({prod[PW-1], prod});
    end

    // Accumulate the partial products phase by phase
    always_ff @(posedge clk) begin
        if (en) begin
            case (ph)
                PH_RE_LOAD: acc_re <= prod_x;
                PH_RE_ADD:  acc_re <= acc_re + prod_x;
                PH_IM_LOAD: acc_im <= prod_x;
                default:    acc_im <= acc_im - prod_x;
            endcase
        end
    end

    // Result formatting
    always_comb begin
        top_re = hs_re;
        top_im = hs_im;
        bot_re = scale_sat(acc_re);
        bot_im = scale_sat(acc_im);
    end
endmodule

// File: rtl/fft_bfly_stage.sv
// One decimation-in-frequency pass of an N-point radix-2 FFT.
// After start (while idle) it issues butterfly b's RAM and twiddle reads in
// cycle 4b, captures in 4b+1, multiplies in 4b+2..4b+5, writes the lower
// result in 4b+4 and the upper result in 4b+6, and pulses done once the last
// write is out. Load-port writes are accepted only while idle.
module fft_bfly_stage
    import fft_stage_pkg::*;
#(
    parameter int N_LOG2 = 8,
    parameter int STAGE  = 0,
    parameter int DATA_W = 16,
    parameter int TW_W   = 16,
    parameter int MUL_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_we,
    input  logic [N_LOG2-1:0] in_addr,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    output logic              out_we,
    output logic [N_LOG2-1:0] out_addr,
    output logic [DATA_W-1:0] out_re,
    output logic [DATA_W-1:0] out_im,
    output logic              done
);
    localparam int NPTS      = 1 << N_LOG2;
    localparam int NBF       = NPTS / 2;
    localparam int BW        = N_LOG2 - 1;
    localparam int SPAN_LOG2 = N_LOG2 - 1 - STAGE;
    localparam int CW        = N_LOG2 + 2;
    localparam logic [CW-1:0] LAST_CYC = CW'(4 * NBF + 2);
    localparam logic [CW-1:0] FIRST_WR = CW'(4);

    logic                     busy;
    logic [CW-1:0]            cyc;
    logic [BW-1:0]            rd_idx, wr_idx;
    logic [2*DATA_W-1:0]      ra_data, rc_data;
    logic signed [TW_W-1:0]   w_cos, w_sin;
    logic signed [DATA_W-1:0] top_re, top_im, bot_re, bot_im;
    logic                     ram_we;
    logic [N_LOG2-1:0]        ram_addr_a;

    // Lower address of butterfly b: a zero inserted at bit SPAN_LOG2
    function automatic logic [N_LOG2-1:0] lo_addr(input logic [BW-1:0] b);
        logic [N_LOG2-1:0] w;
        w = {1'b0, b};
        return ((w >> SPAN_LOG2) << (SPAN_LOG2 + 1)) | (w & N_LOG2'((1 << SPAN_LOG2) - 1));
    endfunction

    // Upper address of butterfly b
    function automatic logic [N_LOG2-1:0] hi_addr(input logic [BW-1:0] b);
        return lo_addr(b) | N_LOG2'(1 << SPAN_LOG2);
    endfunction

    // Twiddle index: position inside the group, stepped by 2^STAGE
    function automatic logic [BW-1:0] tw_idx(input logic [BW-1:0] b);
        return BW'((b & BW'((1 << SPAN_LOG2) - 1)) << STAGE);
    endfunction

    // Pass sequencer: idle/busy, cycle counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cyc  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cyc  <= '0;
                end
            end else if (cyc == LAST_CYC) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cyc <= cyc + CW'(1);
            end
        end
    end

    // Read and write butterfly indices derived from the counter
    always_comb begin
        rd_idx     = cyc[BW+1:2];
        wr_idx     = rd_idx - BW'(1);
        ram_we     = in_we && !busy;
        ram_addr_a = busy ? lo_addr(rd_idx) : in_addr;
    end

    fft_stage_ram #(.AW(N_LOG2), .DW(2 * DATA_W)) u_ram (
        .clk     (clk),
        .a_we    (ram_we),
        .a_addr  (ram_addr_a),
        .a_wdata ({in_re, in_im}),
        .a_rdata (ra_data),
        .b_addr  (hi_addr(rd_idx)),
        .b_rdata (rc_data)
    );

    fft_twiddle_rom #(.N_LOG2(N_LOG2), .TW_W(TW_W)) u_rom (
        .clk   (clk),
        .addr  (tw_idx(rd_idx)),
        .cos_q (w_cos),
        .sin_q (w_sin)
    );

    fft_bfly_datapath #(.DATA_W(DATA_W), .TW_W(TW_W), .MUL_W(MUL_W)) u_dp (
        .clk    (clk),
        .en     (busy),
        .cap    (busy && (cyc[1:0] == 2'd1)),
        .ph     (mul_phase_e'(cyc[1:0])),
        .xa_re  ($signed(ra_data[2*DATA_W-1:DATA_W])),
        .xa_im  ($signed(ra_data[DATA_W-1:0])),
        .xc_re  ($signed(rc_data[2*DATA_W-1:DATA_W])),
        .xc_im  ($signed(rc_data[DATA_W-1:0])),
        .w_cos  (w_cos),
        .w_sin  (w_sin),
        .top_re (top_re),
        .top_im (top_im),
        .bot_re (bot_re),
        .bot_im (bot_im)
    );

    // Result port: lower word on phase 0, upper word on phase 2
    always_comb begin
        out_we   = busy && (cyc >= FIRST_WR) && !cyc[0];
        out_addr = cyc[1] ? hi_addr(wr_idx) : lo_addr(wr_idx);
        out_re   = cyc[1] ? bot_re : top_re;
        out_im   = cyc[1] ? bot_im : top_im;
    end
endmodule

// File: rtl/fft_bfly_stage_chk.sv
// Protocol checker for fft_bfly_stage, attached by bind.
module fft_bfly_stage_chk #(
    parameter int N_LOG2 = 8,
    parameter int STAGE  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              out_we,
    input logic [N_LOG2-1:0] out_addr,
    input logic              done
);
    localparam int SPAN_LOG2 = N_LOG2 - 1 - STAGE;
    localparam logic [N_LOG2-1:0] SPAN_BIT = N_LOG2'(1 << SPAN_LOG2);

    // R7: done lasts one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows the final write directly
    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_we));

    // R6: writes never back to back
    assert_write_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> !out_we);

    // R6: no write outside a pass
    assert_write_in_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> busy);

    // R1: an upper write is preceded two cycles earlier by its lower partner
    assert_pair_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && ((out_addr & SPAN_BIT) != '0)) |->
            ($past(out_we, 2) && (($past(out_addr, 2) | SPAN_BIT) == out_addr)
             && (($past(out_addr, 2) & SPAN_BIT) == '0)));

    // R8: a start during a pass does not end or restart it
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R7: the pass only ends through done
    assert_end_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind fft_bfly_stage fft_bfly_stage_chk #(.N_LOG2(N_LOG2), .STAGE(STAGE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .out_we   (out_we),
    .out_addr (out_addr),
    .done     (done)
);

// File: tb/tb_fft_bfly_stage.sv
// Bench: loads patterns, runs passes, and compares each result word,
// address and cycle against an arithmetic model.
module tb_fft_bfly_stage;
    localparam int LOGN = 8;
    localparam int NP   = 1 << LOGN;
    localparam int STG  = 2;
    localparam int H    = 1 << (LOGN - 1 - STG);
    localparam real PI_V = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_we = 1'b0;
    logic [7:0]  in_addr = '0;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic        out_we;
    logic [7:0]  out_addr;
    logic [15:0] out_re;
    logic [15:0] out_im;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int mre [NP];
    int mim [NP];
    int ere [NP];
    int eim [NP];
    bit esat [NP];
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    fft_bfly_stage #(.N_LOG2(LOGN), .STAGE(STG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_we(in_we), .in_addr(in_addr), .in_re(in_re), .in_im(in_im),
        .out_we(out_we), .out_addr(out_addr), .out_re(out_re), .out_im(out_im),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int tw_q(input real v);
        real r;
        int q;
        r = v * 32768.0;
        q = (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
        if (q > 32767) q = 32767;
        return q;
    endfunction

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int lo_of(input int b);
        return (b / H) * 2 * H + (b % H);
    endfunction

    // Model of one pass from the loaded contents (R1..R5)
    task automatic compute_expected();
        for (int b = 0; b < NP / 2; b++) begin
            int a, c, k, cs, sn;
            longint dr, di, pr, pi;
            a  = lo_of(b);
            c  = a + H;
            k  = (b % H) << STG;
            cs = tw_q($cos(2.0 * PI_V * real'(k) / real'(NP)));
            sn = tw_q($sin(2.0 * PI_V * real'(k) / real'(NP)));
            ere[a] = (mre[a] + mre[c]) >>> 1;
            eim[a] = (mim[a] + mim[c]) >>> 1;
            dr = longint'(mre[a] - mre[c]);
            di = longint'(mim[a] - mim[c]);
            pr = (dr * cs + di * sn) >>> 16;
            pi = (di * cs - dr * sn) >>> 16;
            esat[c] = (pr > 32767) || (pr < -32768) || (pi > 32767) || (pi < -32768);
            esat[a] = 1'b0;
            ere[c] = sat16(pr);
            eim[c] = sat16(pi);
        end
    endtask

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    task automatic set_pattern(input int p);
        for (int k = 0; k < NP; k++) begin
            case (p)
                0: begin mre[k] = (k == 5) ? 2047 : 0; mim[k] = 0; end
                1: begin mre[k] = k * 16 - 2048; mim[k] = 0; end
                2: begin mre[k] = rnd16(); mim[k] = rnd16(); end
                3: begin
                    mre[k] = ((k / H) % 2 == 1) ? -32768 : 32767;
                    mim[k] = mre[k];
                end
                default: begin mre[k] = rnd16() >>> 4; mim[k] = rnd16() >>> 4; end
            endcase
        end
    endtask

    task automatic load_ram();
        for (int k = 0; k < NP; k++) begin
            @(negedge clk);
            in_we   = 1'b1;
            in_addr = 8'(k);
            in_re   = 16'(mre[k]);
            in_im   = 16'(mim[k]);
        end
        @(negedge clk);
        in_we = 1'b0;
    endtask

    // One pass; abuse injects a stray start and busy-time load writes (R8, R9)
    task automatic run_pass(input bit abuse);
        int wcount;
        bit got_done;
        wcount = 0;
        got_done = 1'b0;
        compute_expected();
        @(negedge clk);
        start = 1'b1;
        for (int n = 0; n < 530 && !got_done; n++) begin
            @(negedge clk);
            if (out_we) begin
                int b, ea;
                b  = wcount / 2;
                ea = (wcount % 2 == 0) ? lo_of(b) : lo_of(b) + H;
                check(n == 4 + 2 * wcount, "R6", "write cycle", n, 4 + 2 * wcount);
                check(int'(out_addr) == ea, "R1", "write address", out_addr, ea);
                if (wcount % 2 == 0) begin
                    check(int'($signed(out_re)) == ere[ea], "R2", "sum re", $signed(out_re), ere[ea]);
                    check(int'($signed(out_im)) == eim[ea], "R2", "sum im", $signed(out_im), eim[ea]);
                end else if (esat[ea]) begin
                    check(int'($signed(out_re)) == ere[ea], "R4", "clip re", $signed(out_re), ere[ea]);
                    check(int'($signed(out_im)) == eim[ea], "R4", "clip im", $signed(out_im), eim[ea]);
                end else begin
                    check(int'($signed(out_re)) == ere[ea], "R3 R5", "twiddled re", $signed(out_re), ere[ea]);
                    check(int'($signed(out_im)) == eim[ea], "R3 R5", "twiddled im", $signed(out_im), eim[ea]);
                end
                wcount++;
            end
            if (done) begin
                got_done = 1'b1;
                check(n == 4 * (NP / 2) + 3, "R7", "done cycle", n, 4 * (NP / 2) + 3);
                check(wcount == NP, "R1", "write count", wcount, NP);
            end
            start   = abuse && (n == 100);
            in_we   = abuse && (n >= 40) && (n < 48);
            in_addr = 8'(n);
            in_re   = 16'h5a5a;
            in_im   = 16'ha5a5;
        end
        in_we = 1'b0;
        start = 1'b0;
        check(got_done, "R7", "done seen", got_done, 1);
        @(negedge clk);
        check(!done, "R7", "done width", done, 0);
        check(!out_we, "R6", "quiet after pass", out_we, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_we, "R10", "out_we in reset", out_we, 0);
        check(!done, "R10", "done in reset", done, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(!out_we && !done, "R10", "idle after reset", {out_we, done}, 0);
        end
        for (int p = 0; p < 4; p++) begin
            set_pattern(p);
            load_ram();
            run_pass(1'b0);
        end
        set_pattern(2);
        load_ram();
        run_pass(1'b1);
        run_pass(1'b0);      // R9: no reload, same contents expected
        set_pattern(4);
        load_ram();
        run_pass(1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule